// File: doc/BRIEF.md
# If-Then Predication Sequencer

This block gives conditions to instructions in a compact 16-bit instruction stream that have no condition field of their own. A prefix instruction carries a 4-bit base condition and a then/else mask. The sequencer loads them into a small shift register of slots. Each of the next one to four issued instructions uses one slot. A "then" slot takes effect when the base condition holds against the current N/Z/C/V flags. An "else" slot takes effect when the inverse holds. For each issued instruction the block drives an execute-enable, and a suppressed instruction is still issued and still uses up its slot.

The controller has three states. `ST_IDLE` means no block is open. `ST_BLOCK` means slots remain. `ST_FAULT` lasts one cycle and reports an illegal prefix. The transitions are as follows:
- **load**: IDLE or FAULT to BLOCK, on a legal prefix.
- **step**: BLOCK to BLOCK, on an issue when more than one slot remains.
- **drain**: BLOCK to IDLE, on the issue that uses the last slot.
- **flush**: any state to IDLE.
- **nest**: BLOCK to FAULT, on a prefix that arrives while a block is open.
- **reject**: IDLE or FAULT to FAULT, on a prefix with a reserved condition or an empty mask.
- **settle**: FAULT to IDLE, when no prefix arrives.

Fetch, the compare that sets the flags, and writeback all sit outside this block.

Top module: `itp_seq`

## Requirements
- R1: After reset the outputs are as follows: `blk_active_o` is 0, `pfx_err_o` is 0, and `exec_en_o` is 0 while no issue is present.
- R2: `exec_en_o` is only high when `issue_i` is high. Outside a block, every issue without a prefix or flush in the same cycle executes.
- R3: The mask is 4 bits wide. The position of its lowest set bit gives the block length: bit 3 gives 1 slot, bit 2 gives 2, bit 1 gives 3 and bit 0 gives 4. `blk_active_o` rises in the cycle after a legal prefix. It falls in the cycle after the issue that uses the last slot, and later issues then execute.
- R4: The first slot is always "then". It executes exactly when the base condition holds.
- R5: Mask bit 3 sets slot 2, bit 2 sets slot 3 and bit 1 sets slot 4. A bit equal to bit 0 of the condition marks "then"; otherwise the slot is "else" and executes when the condition fails.
- R6: The flags are `{N,Z,C,V}` in bits 3..0. The conditions are: 0 EQ (Z), 1 NE, 2 CS (C), 3 CC, 4 MI (N), 5 PL, 6 VS (V), 7 VC, 8 HI (C and not Z), 9 LS, 10 GE (N==V), 11 LT, 12 GT (not Z and N==V), 13 LE, 14 always. Flags are read in the cycle of each issue.
- R7: A prefix with condition 15 (reserved) or with mask 0 opens no block. It raises `pfx_err_o` for one cycle, in the cycle after the prefix.
- R8: Slots advance only on issue. Cycles without an issue leave an open block unchanged.
- R9: `flush_i` closes any block from the next cycle. An issue in the flush cycle does not execute.
- R10: A prefix that arrives while a block is open raises `pfx_err_o` in the next cycle and closes the block.
- R11: An instruction suppressed by its slot still uses up that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | A governed-stream instruction issues this cycle |
| pfx_i | input | 1 | A prefix instruction is decoded this cycle |
| pfx_cond_i | input | 4 | Base condition of the prefix |
| pfx_mask_i | input | SLOTS | Length and then/else mask of the prefix |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| flush_i | input | 1 | Flush or exception; closes any block |
| exec_en_o | output | 1 | The issued instruction takes effect |
| blk_active_o | output | 1 | A predicated block is open |
| pfx_err_o | output | 1 | One-cycle illegal-prefix pulse |

## Verification
The bench builds the block with the default `SLOTS = 4`, so every block length from one to four slots can be reached. Mask patterns mix then and else slots against both polarities of the condition's low bit. All fifteen conditions are swept against all sixteen flag combinations. Issue gaps, flushes in the middle of a block, nested prefixes and reserved or empty prefixes are placed at points where a miscount of slots would change the next execute-enable.

// File: rtl/itp_pkg.sv
package itp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BLOCK = 2'd1,
        ST_FAULT = 2'd2
    } seq_state_e;

    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    localparam logic [3:0] COND_RSVD = 4'hF;
endpackage

// File: rtl/itp_cond_eval.sv
module itp_cond_eval
    import itp_pkg::*;
(
    input  logic [3:0] cond_i,
    input  logic [3:0] flags_i,
    output logic       pass_o
);
    logic n, z, c, v, base;

    always_comb begin
        n = flags_i[FLAG_N];
        z = flags_i[FLAG_Z];
        c = flags_i[FLAG_C];
        v = flags_i[FLAG_V];
        unique case (cond_i[3:1])
            3'd0:    base = z;
            3'd1:    base = c;
            3'd2:    base = n;
            3'd3:    base = v;
            3'd4:    base = c & ~z;
            3'd5:    base = (n == v);
            3'd6:    base = ~z & (n == v);
            default: base = 1'b1;
        endcase
        // Pairs differ only in the low bit, which inverts; code 14 is "always".
        pass_o = (cond_i[3:1] == 3'd7) ? 1'b1 : (base ^ cond_i[0]);
    end
endmodule

// File: rtl/itp_mask_decode.sv
module itp_mask_decode #(
    parameter int SLOTS = 4,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic [SLOTS-1:0] mask_i,
    input  logic             cond_lsb_i,
    output logic [CNT_W-1:0] len_o,
    output logic [SLOTS-1:0] then_o,
    output logic             legal_o
);
    // Lowest set bit wins: scan from the top so the last hit is the lowest.
    always_comb begin
        len_o = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (mask_i[i]) len_o = CNT_W'(SLOTS - i);
        end
        legal_o = |mask_i;
    end

    assign then_o[0] = 1'b1;
    for (genvar k = 1; k < SLOTS; k++) begin : g_slot
        assign then_o[k] = (mask_i[SLOTS-k] == cond_lsb_i);
    end
endmodule

// File: rtl/itp_seq.sv
module itp_seq
    import itp_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_i,
    input  logic             pfx_i,
    input  logic [3:0]       pfx_cond_i,
    input  logic [SLOTS-1:0] pfx_mask_i,
    input  logic [3:0]       flags_i,
    input  logic             flush_i,
    output logic             exec_en_o,
    output logic             blk_active_o,
    output logic             pfx_err_o
);
    seq_state_e       state_q, state_d;
    logic [3:0]       cond_q, cond_d;
    logic [SLOTS-1:0] then_q, then_d;
    logic [CNT_W-1:0] left_q, left_d;

    logic [CNT_W-1:0] dec_len;
    logic [SLOTS-1:0] dec_then;
    logic             dec_legal, pfx_ok, cond_pass, slot_pass, step;

    itp_mask_decode #(.SLOTS(SLOTS)) u_dec (
        .mask_i     (pfx_mask_i),
        .cond_lsb_i (pfx_cond_i[0]),
        .len_o      (dec_len),
        .then_o     (dec_then),
        .legal_o    (dec_legal)
    );

    itp_cond_eval u_cond (
        .cond_i  (cond_q),
        .flags_i (flags_i),
        .pass_o  (cond_pass)
    );

    assign pfx_ok    = dec_legal && (pfx_cond_i != COND_RSVD);
    assign slot_pass = then_q[0] ? cond_pass : ~cond_pass;
    assign step      = issue_i && !pfx_i && !flush_i;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cond_q  <= '0;
            then_q  <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            cond_q  <= cond_d;
            then_q  <= then_d;
            left_q  <= left_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        cond_d  = cond_q;
        then_d  = then_q;
        left_d  = left_q;
        unique case (state_q)
            ST_IDLE, ST_FAULT: begin
                if (flush_i) begin
                    state_d = ST_IDLE;                 // flush
                end else if (pfx_i && pfx_ok) begin
                    state_d = ST_BLOCK;                // load
                    cond_d  = pfx_cond_i;
                    then_d  = dec_then;
                    left_d  = dec_len;
                end else if (pfx_i) begin
                    state_d = ST_FAULT;                // reject
                end else begin
                    state_d = ST_IDLE;                 // settle
                end
            end
            ST_BLOCK: begin
                if (flush_i) begin
                    state_d = ST_IDLE;                 // flush
                    left_d  = '0;
                end else if (pfx_i) begin
                    state_d = ST_FAULT;                // nest
                    left_d  = '0;
                end else if (issue_i) begin
                    then_d = then_q >> 1;
                    left_d = left_q - CNT_W'(1);
                    if (left_q == CNT_W'(1)) state_d = ST_IDLE;   // drain
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        blk_active_o = (state_q == ST_BLOCK);
        pfx_err_o    = (state_q == ST_FAULT);
        exec_en_o    = step && ((state_q == ST_BLOCK) ? slot_pass : 1'b1);
    end

    AST_IDLE_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        (!blk_active_o && step) |-> exec_en_o);                          // R2
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        blk_active_o |-> (left_q != '0 && int'(left_q) <= SLOTS));       // R3
    AST_LAST_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_active_o && step && left_q == CNT_W'(1)) |=> !blk_active_o); // R3
    AST_RSVD_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (pfx_i && !flush_i && pfx_cond_i == COND_RSVD) |=> (pfx_err_o && !blk_active_o)); // R7
    AST_HOLD_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_active_o && !issue_i && !pfx_i && !flush_i) |=> (blk_active_o && $stable(left_q))); // R8
    AST_FLUSH_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!blk_active_o && !pfx_err_o));                      // R9
    AST_NEST_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_active_o && pfx_i && !flush_i) |=> (pfx_err_o && !blk_active_o)); // R10
endmodule

// File: tb/sim_itp_seq.sv
module sim_itp_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic issue_i = 1'b0, pfx_i = 1'b0, flush_i = 1'b0;
    logic [3:0] pfx_cond_i = '0, pfx_mask_i = '0, flags_i = '0;
    logic exec_en_o, blk_active_o, pfx_err_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    bit   q_exp[$];
    string q_tag[$];

    always #10 clk = ~clk;   // 50 MHz

    itp_seq u0 (
        .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .pfx_i(pfx_i),
        .pfx_cond_i(pfx_cond_i), .pfx_mask_i(pfx_mask_i), .flags_i(flags_i),
        .flush_i(flush_i), .exec_en_o(exec_en_o),
        .blk_active_o(blk_active_o), .pfx_err_o(pfx_err_o)
    );

    function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
        bit n = f[3], z = f[2], cy = f[1], v = f[0];
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            default: return 1'b1;
        endcase
    endfunction

    task automatic chk(input bit got, input bit exp, input string tag, input string what);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0b expected %0b", tag, what, got, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expected execute-enable queued per issue.
    task automatic cyc(input bit iss, input bit pfx, input logic [3:0] c, input logic [3:0] m,
                       input logic [3:0] f, input bit fl, input bit exp, input string tag);
        @(posedge clk); #2;
        issue_i = iss; pfx_i = pfx; pfx_cond_i = c; pfx_mask_i = m; flags_i = f; flush_i = fl;
        if (iss) begin q_exp.push_back(exp); q_tag.push_back(tag); end
        @(negedge clk);
    endtask

    task automatic idle();                    cyc(0, 0, 4'd0, 4'd0, 4'd0, 0, 0, ""); endtask
    task automatic prefix(input logic [3:0] c, input logic [3:0] m); cyc(0, 1, c, m, 4'd0, 0, 0, ""); endtask
    task automatic issue(input logic [3:0] f, input bit exp, input string tag); cyc(1, 0, 4'd0, 4'd0, f, 0, exp, tag); endtask

    // Monitor: scoreboard compare at mid-cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (issue_i) begin
                if (q_exp.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL R2 unexpected issue: got %0b expected none", exec_en_o);
                end else begin
                    automatic bit e = q_exp.pop_front();
                    automatic string t = q_tag.pop_front();
                    chk(exec_en_o, e, t, "exec_en");
                end
            end else begin
                chk(exec_en_o, 1'b0, "R2", "exec_en without issue");
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(blk_active_o, 0, "R1", "blk_active in reset");
        chk(pfx_err_o, 0, "R1", "pfx_err in reset");
        chk(exec_en_o, 0, "R1", "exec_en in reset");
        @(posedge clk); #2; rst_n = 1'b1;
        @(negedge clk);
        chk(blk_active_o, 0, "R1", "blk_active after reset");

        // R2: plain issues outside a block
        issue(4'h0, 1, "R2"); issue(4'hF, 1, "R2");

        // R3 R4 R5: EQ, mask 0101 -> 4 slots T,T,E,T, Z=1
        prefix(4'd0, 4'b0101);
        issue(4'b0100, 1, "R4"); chk(blk_active_o, 1, "R3", "active after prefix");
        issue(4'b0100, 1, "R5"); issue(4'b0100, 0, "R5"); issue(4'b0100, 1, "R5");
        idle(); chk(blk_active_o, 0, "R3", "closed after 4 slots");
        issue(4'b0000, 1, "R3");

        // R5: NE, mask 1100 -> 2 slots T,T
        prefix(4'd1, 4'b1100);
        issue(4'b0100, 0, "R4"); issue(4'b0000, 1, "R5");
        idle(); chk(blk_active_o, 0, "R3", "closed after 2 slots");

        // R8 R11: GE, mask 1010 -> 3 slots T,E,T; gaps without issue
        prefix(4'd10, 4'b1010);
        idle(); idle(); idle();
        chk(blk_active_o, 1, "R8", "held without issue");
        issue(4'b1000, 0, "R11"); issue(4'b1000, 1, "R5");
        idle(); chk(blk_active_o, 1, "R11", "suppressed slot counted");
        issue(4'b1001, 1, "R5");
        idle(); chk(blk_active_o, 0, "R3", "closed after 3 slots");

        // R3: single slot, mask 1000
        prefix(4'd2, 4'b1000);
        issue(4'b0000, 0, "R4");
        idle(); chk(blk_active_o, 0, "R3", "closed after 1 slot");

        // R6: always with an else slot never executes
        prefix(4'd14, 4'b1100);
        issue(4'b0000, 1, "R6"); issue(4'b1111, 0, "R6");

        // R7: reserved condition and empty mask
        prefix(4'd15, 4'b1000);
        idle(); chk(pfx_err_o, 1, "R7", "reserved cond err");
        chk(blk_active_o, 0, "R7", "reserved cond no block");
        idle(); chk(pfx_err_o, 0, "R7", "err is a single pulse");
        prefix(4'd0, 4'b0000);
        issue(4'b0000, 1, "R7"); chk(pfx_err_o, 1, "R7", "empty mask err");

        // R9: flush mid block
        prefix(4'd0, 4'b0001);
        issue(4'b0100, 1, "R4");
        cyc(1, 0, 4'd0, 4'd0, 4'b0100, 1, 0, "R9");
        idle(); chk(blk_active_o, 0, "R9", "flush closes block");
        issue(4'b0000, 1, "R9");

        // R10: nested prefix
        prefix(4'd0, 4'b0001);
        issue(4'b0100, 1, "R4");
        prefix(4'd1, 4'b1000);
        idle(); chk(pfx_err_o, 1, "R10", "nested prefix err");
        chk(blk_active_o, 0, "R10", "nested prefix closes");
        issue(4'b0000, 1, "R10");

        // R6: condition sweep
        for (int c = 0; c < 15; c++) begin
            for (int f = 0; f < 16; f++) begin
                prefix(4'(c), 4'b1000);
                issue(4'(f), cond_ok(4'(c), 4'(f)), "R6");
            end
        end

        idle();
        n_chk++;
        if (q_exp.size() != 0) begin
            n_fail++;
            $display("FAIL R2 pending: got %0d expected 0", q_exp.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule